// File: doc/BRIEF.md
# PC-Relative Next-PC Unit

This block sits beside the execute stage of a 32-bit integer core. For each valid instruction it works out where the program goes next and what value, if any, goes back to the destination register. It covers the upper-immediate loads (absolute and PC-relative), the two jumps (PC-relative and register-based) and the six conditional branches. For these it rebuilds the immediate from its scattered bit fields, compares the two source operands for branches, and forms either the link address or the upper-immediate result.

Every other instruction gets the sequential address (PC + 4) and no write-back. The result appears on registered outputs one clock after the valid strobe. Between valid inputs the outputs keep their last values. Register read, fetch, memory access and traps on misaligned targets are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid` and `wb_en` are 0.
- R2: `out_valid` is 1 exactly one clock after `in_valid` was 1. If `in_valid` is 0, `next_pc` and `wb_data` keep their values on the next clock.
- R3: Opcode `instr[6:0]`=0110111 writes `instr[31:12]` followed by twelve zero bits. The next PC is PC+4.
- R4: Opcode 0010111 writes PC plus (`instr[31:12]` followed by twelve zeros), modulo 2^32. The next PC is PC+4.
- R5: Opcode 1101111 writes PC+4. The next PC is PC plus a sign-extended byte offset built from `instr[31]`,`instr[19:12]`,`instr[20]`,`instr[30:21]`, with a zero appended as bit 0.
- R6: Opcode 1100111 writes PC+4. The next PC is `src_a` plus the sign-extended `instr[31:20]`, with bit 0 forced to 0.
- R7: Opcode 1100011 with funct3 `instr[14:12]` = 000 branches when `src_a`==`src_b`, and with 001 when they differ. A taken branch goes to PC plus a sign-extended offset built from `instr[31]`,`instr[7]`,`instr[30:25]`,`instr[11:8]`, with a zero appended.
- R8: Branch funct3 100 branches when `src_a` < `src_b` as signed values. Funct3 101 branches when `src_a` >= `src_b` as signed values.
- R9: Branch funct3 110 and 111 perform the same less-than and greater-or-equal tests on unsigned values.
- R10: A branch that is not taken, a branch with funct3 010 or 011, and any other opcode give next PC = PC+4. In all of these cases `wb_en` is 0. For an opcode this block does not handle, `wb_data` is 0.
- R11: `wb_en` is 0 when the destination field `instr[11:7]` is 0, even for the four writing instructions. `wb_data` still carries the computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| cur_pc | input | 32 | Address of the instruction |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| instr | input | 32 | Raw instruction word |
| out_valid | output | 1 | Result registers hold a new result |
| next_pc | output | 32 | Address of the next instruction |
| wb_data | output | 32 | Value for the destination register |
| wb_en | output | 1 | Destination register write request |

## Verification
The two jumps redirect the program and produce a link value in the same result cycle. Both fields must come from the same instruction: the target from the offset or the register sum, and the link from the sequential adder. The bench feeds jumps back-to-back with branches and upper-immediate loads, and compares `next_pc` and `wb_data` of the same output cycle against hand-computed values. The cases include a register jump whose sum is odd, and offsets at the extreme positive and negative ends. A zero destination field combined with a jump also checks that the redirect still happens while the write request is suppressed.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W  = 7;
  localparam int unsigned F3_W   = 3;
  localparam int unsigned REG_W  = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_LUI    = 7'b0110111,
    OPC_AUIPC  = 7'b0010111,
    OPC_JAL    = 7'b1101111,
    OPC_JALR   = 7'b1100111,
    OPC_BRANCH = 7'b1100011
  } opc_e;

  typedef enum logic [F3_W-1:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_e;
endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/npc_imm_gen.sv
module npc_imm_gen #(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:7]     fields,
  output logic [XLEN-1:0] imm_u,
  output logic [XLEN-1:0] imm_j,
  output logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] imm_b
);
  // every format keeps its sign in bit 31; size casts of signed values sign-extend
  assign imm_u = XLEN'($signed({fields[31:12], 12'b0}));
  assign imm_j = XLEN'($signed({fields[31], fields[19:12], fields[20], fields[30:21], 1'b0}));
  assign imm_i = XLEN'($signed(fields[31:20]));
  assign imm_b = XLEN'($signed({fields[31], fields[7], fields[30:25], fields[11:8], 1'b0}));
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [F3_W-1:0] sel,
  output logic            take
);
  logic is_eq, lt_s, lt_u;

  assign is_eq = (lhs == rhs);
  assign lt_s  = ($signed(lhs) < $signed(rhs));
  assign lt_u  = (lhs < rhs);

  always_comb begin
    take = 1'b0;
    case (sel)
      CMP_EQ:  take = is_eq;
      CMP_NE:  take = !is_eq;
      CMP_LT:  take = lt_s;
      CMP_GE:  take = !lt_s;
      CMP_LTU: take = lt_u;
      CMP_GEU: take = !lt_u;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [31:0]     instr,
  output logic            out_valid,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_en
);
  localparam int unsigned INSN_BYTES = INSN_W / 8;
  localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(INSN_BYTES);

  logic rst_q_n;
  npc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .rst_q_n(rst_q_n)
  );

  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] rd_idx;
  logic [F3_W-1:0]  f3;
  assign opc    = instr[OPC_W-1:0];
  assign rd_idx = instr[11:7];
  assign f3     = instr[14:12];

  logic [XLEN-1:0] imm_u, imm_j, imm_i, imm_b;
  npc_imm_gen #(.XLEN(XLEN)) i_imm (
    .fields(instr[31:7]), .imm_u(imm_u), .imm_j(imm_j), .imm_i(imm_i), .imm_b(imm_b)
  );

  logic br_take;
  npc_cond_eval #(.XLEN(XLEN)) i_cmp (
    .lhs(src_a), .rhs(src_b), .sel(f3), .take(br_take)
  );

  // three adders: sequential, PC-relative (shared offset mux), register-based
  logic [XLEN-1:0] seq_pc, rel_off, rel_pc, reg_sum;
  assign seq_pc  = cur_pc + SEQ_STEP;
  assign reg_sum = src_a + imm_i;

  always_comb begin
    case (opc)
      OPC_AUIPC: rel_off = imm_u;
      OPC_JAL:   rel_off = imm_j;
      default:   rel_off = imm_b;
    endcase
  end
  assign rel_pc = cur_pc + rel_off;

  logic [XLEN-1:0] pc_d, wb_d;
  logic            wants_wb, wb_en_d;

  always_comb begin
    pc_d     = seq_pc;
    wb_d     = '0;
    wants_wb = 1'b0;
    case (opc)
      OPC_LUI: begin
        wb_d     = imm_u;
        wants_wb = 1'b1;
      end
      OPC_AUIPC: begin
        wb_d     = rel_pc;
        wants_wb = 1'b1;
      end
      OPC_JAL: begin
        pc_d     = rel_pc;
        wb_d     = seq_pc;
        wants_wb = 1'b1;
      end
      OPC_JALR: begin
        pc_d     = {reg_sum[XLEN-1:1], 1'b0};
        wb_d     = seq_pc;
        wants_wb = 1'b1;
      end
      OPC_BRANCH: begin
        if (br_take) pc_d = rel_pc;
      end
      default: ;
    endcase
  end

  assign wb_en_d = in_valid && wants_wb && (rd_idx != '0);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      next_pc   <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= wb_en_d;
      if (in_valid) begin
        next_pc <= pc_d;
        wb_data <= wb_d;
      end
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] cur_pc,
  input logic [31:0]     instr,
  input logic            out_valid,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] wb_data,
  input logic            wb_en
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(wb_data)));

  assert_wben_only_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

  assert_lui_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[6:0] == OPC_LUI) |=> (wb_data == XLEN'($signed({$past(instr[31:12]), 12'b0}))));

  assert_jal_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[6:0] == OPC_JAL) |=> (wb_data == $past(cur_pc) + XLEN'(4)));

  assert_jalr_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[6:0] == OPC_JALR) |=> !next_pc[0]);

  assert_bad_branch_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[6:0] == OPC_BRANCH && instr[14:13] == 2'b01)
      |=> (next_pc == $past(cur_pc) + XLEN'(4) && !wb_en));

  assert_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:7] == 5'd0) |=> !wb_en);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) i_npc_unit_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .cur_pc(cur_pc), .instr(instr),
  .out_valid(out_valid), .next_pc(next_pc), .wb_data(wb_data), .wb_en(wb_en)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rd, input logic [6:0] op);
    return {imm, 5'd1, 3'b000, rd, op};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] pc, a, b, ins, epc, ewb;
    logic        een;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{"R3 ", 32'h100,      0, 0, enc_u(20'h12345, 5'd5, 7'b0110111),  32'h104,      32'h12345000, 1'b1},
    '{"R4 ", 32'h800012f4, 0, 0, enc_u(20'h10001, 5'd22, 7'b0010111), 32'h800012f8, 32'h900022f4, 1'b1},
    '{"R4 ", 32'h3000,     0, 0, enc_u(20'hfffff, 5'd3, 7'b0010111),  32'h3004,     32'h2000,     1'b1},
    '{"R5 ", 32'h1000,     0, 0, enc_j(21'h000800, 5'd1), 32'h1800,     32'h1004,     1'b1},
    '{"R5 ", 32'h2000,     0, 0, enc_j(21'h1ffffc, 5'd1), 32'h1ffc,     32'h2004,     1'b1},
    '{"R5 ", 32'h0,        0, 0, enc_j(21'h0ffffe, 5'd1), 32'h000ffffe, 32'h4,        1'b1},
    '{"R5 ", 32'h00200000, 0, 0, enc_j(21'h100000, 5'd1), 32'h00100000, 32'h00200004, 1'b1},
    '{"R6 ", 32'h400, 32'h3001, 0, enc_i(12'h010, 5'd1, 7'b1100111), 32'h3010, 32'h404, 1'b1},
    '{"R6 ", 32'h500, 32'h1000, 0, enc_i(12'hfff, 5'd2, 7'b1100111), 32'hffe,  32'h504, 1'b1},
    '{"R7 ", 32'h600, 7, 7, enc_b(13'h0020, 3'b000), 32'h620, 0, 1'b0},
    '{"R7 ", 32'h600, 7, 8, enc_b(13'h0020, 3'b000), 32'h604, 0, 1'b0},
    '{"R7 ", 32'h600, 7, 8, enc_b(13'h1ff8, 3'b001), 32'h5f8, 0, 1'b0},
    '{"R7 ", 32'h600, 7, 7, enc_b(13'h1ff8, 3'b001), 32'h604, 0, 1'b0},
    '{"R8 ", 32'h700, 32'hffffffff, 1, enc_b(13'h0040, 3'b100), 32'h740, 0, 1'b0},
    '{"R9 ", 32'h700, 32'hffffffff, 1, enc_b(13'h0040, 3'b110), 32'h704, 0, 1'b0},
    '{"R8 ", 32'h700, 1, 32'hffffffff, enc_b(13'h0040, 3'b101), 32'h740, 0, 1'b0},
    '{"R9 ", 32'h700, 1, 32'hffffffff, enc_b(13'h0040, 3'b111), 32'h704, 0, 1'b0},
    '{"R8 ", 32'h700, 5, 5, enc_b(13'h0040, 3'b101), 32'h740, 0, 1'b0},
    '{"R9 ", 32'h700, 1, 32'hffffffff, enc_b(13'h0040, 3'b110), 32'h740, 0, 1'b0},
    '{"R9 ", 32'h700, 32'h80000000, 32'h7fffffff, enc_b(13'h0040, 3'b111), 32'h740, 0, 1'b0},
    '{"R7 ", 32'h2000, 0, 0, enc_b(13'h1000, 3'b000), 32'h1000, 0, 1'b0},
    '{"R7 ", 32'h0,    0, 0, enc_b(13'h0ffe, 3'b000), 32'hffe,  0, 1'b0},
    '{"R11", 32'h800, 0, 0, enc_u(20'habcde, 5'd0, 7'b0110111), 32'h804, 32'habcde000, 1'b0},
    '{"R11", 32'h900, 0, 0, enc_j(21'h000008, 5'd0), 32'h908, 32'h904, 1'b0},
    '{"R10", 32'ha00, 0, 0, enc_i(12'h123, 5'd5, 7'b0010011), 32'ha04, 0, 1'b0},
    '{"R10", 32'hb00, 0, 0, enc_b(13'h0040, 3'b010), 32'hb04, 0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] cur_pc, src_a, src_b, instr;
  logic        out_valid, wb_en;
  logic [31:0] next_pc, wb_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc), .src_a(src_a),
    .src_b(src_b), .instr(instr), .out_valid(out_valid), .next_pc(next_pc),
    .wb_data(wb_data), .wb_en(wb_en)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] ins);
    in_valid = v; cur_pc = pc; src_a = a; src_b = b; instr = ins;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {31'b0, out_valid}, 0);
    check("R1", "wb_en in reset", {31'b0, wb_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "out_valid after release", {31'b0, out_valid}, 0);
    check("R1", "wb_en after release", {31'b0, wb_en}, 0);

    // back-to-back vector walk: drive at a falling edge, sample at the next one
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].pc, VECS[i].a, VECS[i].b, VECS[i].ins);
      @(negedge clk);
      check(string'(VECS[i].tag), "next_pc", next_pc, VECS[i].epc);
      check(string'(VECS[i].tag), "wb_data", wb_data, VECS[i].ewb);
      check(string'(VECS[i].tag), "wb_en", {31'b0, wb_en}, {31'b0, VECS[i].een});
      check("R2", "out_valid", {31'b0, out_valid}, 1);
    end

    // R2: an idle cycle keeps results while other inputs move
    drive(1'b1, 32'hc00, 0, 0, enc_u(20'h0abcd, 5'd9, 7'b0110111));
    @(negedge clk);
    drive(1'b0, 32'hd00, 0, 0, enc_j(21'h000100, 5'd1));
    @(negedge clk);
    check("R2", "idle out_valid", {31'b0, out_valid}, 0);
    check("R2", "idle next_pc held", next_pc, 32'hc04);
    check("R2", "idle wb_data held", wb_data, 32'h0abcd000);
    check("R2", "idle wb_en", {31'b0, wb_en}, 0);

    // R5 / R6 combined: jalr with negative immediate wrapping below zero
    drive(1'b1, 32'he00, 32'h3, 0, enc_i(12'hffc, 5'd7, 7'b1100111));
    @(negedge clk);
    check("R6", "jalr wrap target", next_pc, 32'hfffffffe);
    check("R6", "jalr link", wb_data, 32'he04);
    drive(1'b0, 0, 0, 0, 0);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule